// File: doc/BRIEF.md
# Triggered Circular Capture Controller

This block is the recording half of an on-chip signal probe. On every clock it takes one sample of a bundle of probed signals and writes it into a circular sample memory at the next sequential address. At the same time it watches a single trigger bit and tests it against a selected condition: rising edge, falling edge, low level or high level. Once the condition is met, a percentage input fixes how much of the stored window comes before the trigger. The block then stores just enough further samples to complete the window.

When the window is complete the block raises a one-cycle finish strobe and presents the memory address where the window begins, so that a separate readout stage can walk the memory from there. After finishing, the block ignores all further samples and trigger events until its enable is released and applied again. Enable and reset polarity are parameters. Memory readout and register access sit outside this block.

Top module: `trig_capture`

## Requirements
- R1: While reset is applied, and on the cycle after it is released, the write enable and the finish strobe are low and the window start address is zero.
- R2: From the cycle after the enable is seen active, each cycle with the sample-valid input high writes that sample one clock later. The first write goes to address 0 and each following write to the previous address plus one, modulo the depth. Cycles with sample-valid low produce no write and do not advance the address.
- R3: Trigger kind encoding: 0 fires on a rising edge, 1 on a falling edge, 2 when the trigger bit is 0, 3 when it is 1. Only valid samples are evaluated, and the trigger value on invalid cycles is ignored.
- R4: Edge kinds compare the trigger bit with its value on the previous valid sample since arming. The first valid sample after arming never counts as an edge.
- R5: The number of stored samples before the trigger sample is pre = floor(p × depth / 100), capped at depth − 1, where p is the position input clamped to 100. The number stored after the trigger sample is depth − 1 − pre.
- R6: The window start address is (trigger sample address − pre) modulo the depth. It is valid when the finish strobe rises and is held until the next trigger.
- R7: At position 100 the trigger sample is the last one written. At position 0 the window starts at the trigger sample's address.
- R8: The finish strobe is high for exactly one cycle, in the same cycle as the final write of the window.
- R9: After the finish strobe no write and no further finish occur, whatever the samples and trigger do, until the enable goes inactive. Once the enable is active again, a new capture starts at address 0.
- R10: A trigger that comes before pre samples have been stored completes the window with no extra wait. The start address still follows R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, polarity set by RST_HIGH |
| en_i | input | 1 | Capture enable, polarity set by EN_HIGH |
| smp_valid_i | input | 1 | Probe sample valid |
| smp_data_i | input | DATA_W | Probe sample bundle |
| trig_i | input | 1 | Trigger bit |
| trig_kind_i | input | 2 | Trigger condition (R3 encoding) |
| pre_pct_i | input | 7 | Pre-trigger share in percent |
| mem_we_o | output | 1 | Sample memory write enable |
| mem_addr_o | output | ADDR_W | Sample memory write address |
| mem_wdata_o | output | DATA_W | Sample memory write data |
| win_start_o | output | ADDR_W | Address of the first sample of the window |
| done_o | output | 1 | One-cycle finish strobe |

## Verification
The properties assume that reset is held across at least one clock edge. They also assume that, once a capture is armed, the enable stays active until the finish strobe unless the capture is being deliberately abandoned, and that the trigger kind and position stay constant while it runs. The stimulus changes kind and position only while the enable is inactive, and it holds the enable until some cycles after finish. It also inserts invalid cycles that carry the opposite trigger value and junk data, and after finish it keeps the trigger condition true so that lockout is tested.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        TRG_RISE = 2'd0,
        TRG_FALL = 2'd1,
        TRG_LOW  = 2'd2,
        TRG_HIGH = 2'd3
    } trig_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_POST,
        ST_LOCK
    } cap_state_e;

    // Samples kept ahead of the trigger sample for a given percentage.
    function automatic int unsigned pre_len(input logic [6:0] pct, input int unsigned depth);
        int unsigned p;
        int unsigned n;
        p = (pct > 7'd100) ? 32'd100 : 32'(pct);
        n = (p * depth) / 32'd100;
        if (n > depth - 1) n = depth - 1;
        return n;
    endfunction

endpackage

// File: rtl/cap_trig_eval.sv
module cap_trig_eval
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       smp_en,
    input  logic       trig,
    input  trig_kind_e kind,
    output logic       hit
);
    logic prev_q;
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (smp_en) begin
            prev_q <= trig;
            seen_q <= 1'b1;
        end
    end

    logic cond;
    always_comb begin
        unique case (kind)
            TRG_RISE: cond = seen_q && !prev_q && trig;
            TRG_FALL: cond = seen_q && prev_q && !trig;
            TRG_LOW:  cond = !trig;
            default:  cond = trig;
        endcase
    end

    assign hit = smp_en && cond;

endmodule

// File: rtl/cap_window.sv
module cap_window
    import cap_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [6:0]        pct,
    input  logic [ADDR_W-1:0] trig_addr,
    output logic [ADDR_W-1:0] post_len,
    output logic [ADDR_W-1:0] start
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] pre;

    assign pre      = ADDR_W'(pre_len(pct, DEPTH));
    assign post_len = ADDR_W'(DEPTH - 1) - pre;
    assign start    = trig_addr - pre;

endmodule

// File: rtl/trig_capture.sv
module trig_capture
    import cap_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter bit RST_HIGH = 1'b1,
    parameter bit EN_HIGH  = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic              trig_i,
    input  logic [1:0]        trig_kind_i,
    input  logic [6:0]        pre_pct_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [ADDR_W-1:0] win_start_o,
    output logic              done_o
);
    logic rst_act;
    logic en_act;
    assign rst_act = RST_HIGH ? rst_i : !rst_i;
    assign en_act  = EN_HIGH  ? en_i  : !en_i;

    cap_state_e        state_q;
    logic [ADDR_W-1:0] wptr_q;
    logic [ADDR_W-1:0] remain_q;

    logic recording;
    logic smp_en;
    logic hit;
    logic [ADDR_W-1:0] post_len;
    logic [ADDR_W-1:0] start_addr;

    assign recording = (state_q == ST_PRE) || (state_q == ST_POST);
    assign smp_en    = recording && en_act && smp_valid_i;

    cap_trig_eval u_trig (
        .clk    (clk_i),
        .rst    (rst_act),
        .clear  (state_q == ST_IDLE),
        .smp_en (smp_en && (state_q == ST_PRE)),
        .trig   (trig_i),
        .kind   (trig_kind_e'(trig_kind_i)),
        .hit    (hit)
    );

    cap_window #(.ADDR_W(ADDR_W)) u_win (
        .pct       (pre_pct_i),
        .trig_addr (wptr_q),
        .post_len  (post_len),
        .start     (start_addr)
    );

    always_ff @(posedge clk_i) begin
        if (rst_act) begin
            state_q     <= ST_IDLE;
            wptr_q      <= '0;
            remain_q    <= '0;
            mem_we_o    <= 1'b0;
            mem_addr_o  <= '0;
            mem_wdata_o <= '0;
            win_start_o <= '0;
            done_o      <= 1'b0;
        end else begin
            mem_we_o <= 1'b0;
            done_o   <= 1'b0;
            if (smp_en) begin
                mem_we_o    <= 1'b1;
                mem_addr_o  <= wptr_q;
                mem_wdata_o <= smp_data_i;
                wptr_q      <= wptr_q + 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    wptr_q <= '0;
                    if (en_act) state_q <= ST_PRE;
                end
                ST_PRE: begin
                    if (!en_act) begin
                        state_q <= ST_IDLE;
                    end else if (hit) begin
                        win_start_o <= start_addr;
                        remain_q    <= post_len;
                        if (post_len == '0) begin
                            state_q <= ST_LOCK;
                            done_o  <= 1'b1;
                        end else begin
                            state_q <= ST_POST;
                        end
                    end
                end
                ST_POST: begin
                    if (!en_act) begin
                        state_q <= ST_IDLE;
                    end else if (smp_en) begin
                        remain_q <= remain_q - 1'b1;
                        if (remain_q == ADDR_W'(1)) begin
                            state_q <= ST_LOCK;
                            done_o  <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (!en_act) state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              smp_valid,
    input logic [DATA_W-1:0] smp_data,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              done
);
    a_r2_write_from_valid: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(smp_valid) && $past(en)));

    a_r2_data_follows: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == $past(smp_data)));

    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_with_write: assert property (@(posedge clk) disable iff (rst)
        done |-> mem_we);

    a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !mem_we);

endmodule

bind trig_capture cap_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk_i),
    .rst       (rst_act),
    .en        (en_act),
    .smp_valid (smp_valid_i),
    .smp_data  (smp_data_i),
    .mem_we    (mem_we_o),
    .mem_addr  (mem_addr_o),
    .mem_wdata (mem_wdata_o),
    .done      (done_o)
);

// File: tb/sim_trig_capture.sv
module sim_trig_capture;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int D  = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic vld = 1'b0;
    logic [DW-1:0] dat = '0;
    logic trg = 1'b0;
    logic [1:0] kind = 2'd0;
    logic [6:0] pct = 7'd0;
    logic we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [AW-1:0] wstart;
    logic done;

    always #5 clk = ~clk;

    trig_capture #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk_i(clk), .rst_i(rst), .en_i(en), .smp_valid_i(vld), .smp_data_i(dat),
        .trig_i(trg), .trig_kind_i(kind), .pre_pct_i(pct),
        .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
        .win_start_o(wstart), .done_o(done)
    );

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } wr_t;

    wr_t exp_q[$];
    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;
    logic [AW-1:0] exp_start = '0;
    int seq = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: compare every write and finish against the scoreboard.
    always @(negedge clk) begin
        if (!rst) begin
            if (we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected write addr", int'(addr), -1);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    check(addr == e.a, "R2 write address", int'(addr), int'(e.a));
                    check(wdata == e.d, "R2 write data", int'(wdata), int'(e.d));
                end
            end
            if (done) begin
                done_cnt++;
                check(wstart == exp_start, "R6 window start", int'(wstart), int'(exp_start));
                check(exp_q.size() == 0, "R8 finish with final write", exp_q.size(), 0);
            end
        end
    end

    function automatic logic [63:0] from_bit(input int n);
        return ~((64'd1 << n) - 64'd1);
    endfunction

    // Reference: index of the first valid sample meeting the condition.
    function automatic int find_trig(input int k, input logic [63:0] pat);
        for (int i = 0; i < 64; i++) begin
            logic c;
            case (k)
                0: c = (i > 0) && !pat[i-1] && pat[i];
                1: c = (i > 0) && pat[i-1] && !pat[i];
                2: c = !pat[i];
                default: c = pat[i];
            endcase
            if (c) return i;
        end
        return -1;
    endfunction

    task automatic capture(input int p, input int k, input logic [63:0] pat,
                           input int gap, input int extra, input string tag);
        int t;
        int pre;
        int post;
        int last;
        int pc;
        int done_before;
        t   = find_trig(k, pat);
        pc  = (p > 100) ? 100 : p;
        pre = (pc * D) / 100;
        if (pre > D - 1) pre = D - 1;
        post = D - 1 - pre;
        last = t + post;
        exp_start = AW'(t - pre);
        for (int i = 0; i <= last; i++) begin
            wr_t e;
            e.a = AW'(i);
            e.d = DW'(seq + i);
            exp_q.push_back(e);
        end
        done_before = done_cnt;
        @(negedge clk);
        pct = 7'(p);
        kind = 2'(k);
        en = 1'b1;
        @(negedge clk);
        for (int i = 0; i <= last + extra; i++) begin
            if (gap > 0 && (i % gap) == gap - 1) begin
                vld = 1'b0;
                trg = ~pat[i];
                dat = 8'hEE;
                @(negedge clk);
            end
            vld = 1'b1;
            trg = pat[i];
            dat = DW'(seq);
            seq++;
            @(negedge clk);
        end
        vld = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, {"R2 all writes seen ", tag}, exp_q.size(), 0);
        check(done_cnt == done_before + 1, {"R9 one finish ", tag}, done_cnt - done_before, 1);
        check(wstart == exp_start, {"R6 start held ", tag}, int'(wstart), int'(exp_start));
        exp_q.delete();
        en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(we == 1'b0, "R1 no write in reset", int'(we), 0);
        check(done == 1'b0, "R1 no finish in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(we == 1'b0 && done == 1'b0, "R1 quiet after reset", int'(we) + int'(done), 0);
        check(wstart == '0, "R1 start zero", int'(wstart), 0);
        // R3 R5 rising edge at 50 percent, with invalid gaps
        capture(50, 0, from_bit(20), 3, 4, "R3 rise 50");
        // R7 position 100 high level, trigger stays true afterwards (R9 lockout)
        capture(100, 3, from_bit(18), 0, 6, "R7 pos100");
        // R7 position 0 falling edge
        capture(0, 1, (64'd1 << 5) - 64'd1, 0, 3, "R7 pos0");
        // R10 early low-level trigger at 30 percent
        capture(30, 2, 64'd7, 0, 3, "R10 early");
        // R4 trigger high from the first sample is not an edge
        capture(70, 0, from_bit(12) | ((64'd1 << 10) - 64'd1), 2, 2, "R4 no false edge");
        // R5 position above 100 is treated as 100
        capture(127, 3, from_bit(7), 0, 2, "R5 clamp");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule